// File: doc/BRIEF.md
# Table-seeded sine/cosine pipeline

The block turns an unsigned phase word into a signed sine and cosine pair. The phase word spans one full turn. It is cut into a quadrant, a coarse sector index and a fine residual. The coarse index addresses a table of sector-centre sine values that is computed while the design elaborates. Two reads of that one table give both coordinates of a starting vector that already lies within half a sector of the target angle. A short chain of rotation stages then removes the remaining fine angle.

The rotation stages use a residual angle that is doubled after every stage. Because of this, each stage adds or subtracts the same constant, and no per-stage arctangent table is needed. The result is folded back into the correct quadrant by swapping and negating. The table already carries the rotation gain correction, so the outputs need no multiplier.

The pipeline is fully unrolled. It takes one phase per clock and delivers one result pair per clock, with a fixed latency. It suits oscillators and mixers that need a new sample on every cycle.

Top module: `sincos_seeded`

## Requirements
- R1: The phase word spans one full turn over 2^PHASE_W counts. Its top 2 bits select the quadrant, the next IDX_W bits select the table sector, and the remaining PHASE_W-2-IDX_W bits are the fine residual within the sector.
- R2: For every phase p, sin_out and cos_out are each within ±3 LSB of round(AMP·sin(2πp/2^PHASE_W)) and round(AMP·cos(2πp/2^PHASE_W)), where AMP = 2^(OUT_W-1)-1.
- R3: A phase accepted with phase_vld high yields exactly one result with out_vld high, STAGES+2 clock cycles later. Results leave in arrival order, a new phase may be accepted on every cycle, and cycles with phase_vld low produce no result.
- R4: A synchronous reset clears every valid flag in the pipeline. out_vld is low on the first cycle after reset is released, and phases that were in flight when reset was asserted never produce a result.
- R5: Results for the four quarter turns of one phase p (quadrant field 00) are exactly related. Quadrant 01 gives cos = -sin(p) and sin = cos(p). Quadrant 10 gives cos = -cos(p) and sin = -sin(p). Quadrant 11 gives cos = sin(p) and sin = -cos(p). Here sin(p) and cos(p) mean the block's own outputs for p.
- R6: sin_out is negative only when the top phase bit is 1. cos_out is negative only when the top two phase bits differ. With quadrant field 00, both outputs are zero or positive.
- R7: Neither output ever exceeds AMP in magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| phase_vld | input | 1 | Phase word is valid this cycle |
| phase | input | PHASE_W | Unsigned phase, full turn = 2^PHASE_W |
| out_vld | output | 1 | sin_out and cos_out carry a result |
| sin_out | output | OUT_W | Signed sine, scaled to AMP |
| cos_out | output | OUT_W | Signed cosine, scaled to AMP |

## Verification
Every phase of the default 16-bit configuration is streamed back to back, with the four quarter-turn copies of each base phase sent consecutively. This single sweep does three things. It compares every output pair against an arithmetic sine reference. It exposes any asymmetry between the seed swap, the rotation-direction flip and the sign fold through the exact quadrant relations. It confirms the fixed latency and the ordering under full throughput.

A second run feeds pseudo-random phases with irregular gaps in the valid strobe. This separates correct valid tracking from a pipeline that only works when it is full. A reset is also applied while phases are in flight, to show that they are dropped rather than leaking out afterwards.

// File: rtl/sincos_seed_pkg.sv
package sincos_seed_pkg;

    // pi in Q30
    localparam longint unsigned PI_Q30  = 64'd3373259426;
    localparam longint unsigned ONE_Q30 = 64'd1 << 30;

    // Sine of a Q30 angle in [0, pi/2], by an alternating power series.
    function automatic longint unsigned sin_q30(input longint unsigned a);
        longint unsigned a2;
        longint unsigned term;
        longint unsigned acc_pos;
        longint unsigned acc_neg;
        longint unsigned dv;
        a2      = (a * a) >> 30;
        term    = a;
        acc_pos = a;
        acc_neg = 64'd0;
        for (int k = 1; k <= 7; k++) begin
            dv   = 64'(2 * k) * 64'(2 * k + 1);
            term = ((term * a2) >> 30) / dv;
            if ((k % 2) == 1) acc_neg = acc_neg + term;
            else              acc_pos = acc_pos + term;
        end
        return (acc_pos > acc_neg) ? (acc_pos - acc_neg) : 64'd0;
    endfunction

    // Reciprocal of the gain of the fine rotation chain, Q30.
    function automatic longint unsigned inv_gain_q30(input int idx_w, input int stages);
        longint unsigned g;
        g = ONE_Q30;
        for (int i = 0; i < stages; i++) begin
            int e;
            e = 29 - 2 * (idx_w + i);
            if (e >= 0) g = g - (64'd1 << e);
        end
        return g;
    endfunction

    // Gain-corrected, scaled sine at the centre of sector i.
    function automatic longint unsigned seed_entry(input int i, input int idx_w,
                                                   input int stages,
                                                   input longint unsigned amp_g);
        longint unsigned ang;
        longint unsigned s;
        longint unsigned v;
        ang = (PI_Q30 * 64'(2 * i + 1)) / (64'd4 << idx_w);
        s   = sin_q30(ang);
        v   = (s * inv_gain_q30(idx_w, stages)) >> 30;
        return (v * amp_g + (64'd1 << 29)) >> 30;
    endfunction

    // First fine rotation angle expressed in scaled residual units.
    function automatic int step_angle(input int res_w, input int guard);
        return int'(((64'd1 << (res_w + guard + 31)) + PI_Q30 / 2) / PI_Q30);
    endfunction

endpackage

// File: rtl/sincos_seed_rom.sv
module sincos_seed_rom #(
    parameter int PHASE_W = 16,
    parameter int IDX_W   = 9,
    parameter int XW      = 21,
    parameter int TW      = 19,
    parameter int ZW      = 16,
    parameter int ZGUARD  = 8,
    parameter int STAGES  = 7,
    parameter int AMPG    = 524272
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_in,
    input  logic [PHASE_W-1:0]       phase_in,
    output logic                     vld_o,
    output logic [1:0]               quad_o,
    output logic signed [XW-1:0]     x_o,
    output logic signed [XW-1:0]     y_o,
    output logic signed [ZW-1:0]     z_o
);
    localparam int RES_W = PHASE_W - 2 - IDX_W;
    localparam int TBL_N = 1 << IDX_W;
    localparam int HALF  = 1 << (RES_W - 1);

    typedef struct packed {
        logic                 vld;
        logic [1:0]           quad;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
    } seed_t;

    logic [TW-1:0] tbl [TBL_N];

    for (genvar e = 0; e < TBL_N; e++) begin : g_tbl
        assign tbl[e] = TW'(sincos_seed_pkg::seed_entry(e, IDX_W, STAGES, 64'(AMPG)));
    end

    seed_t seed_d, seed_q;
    logic [1:0]       quad;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] mir;
    logic [RES_W-1:0] res;
    logic [TW-1:0]    rd_a;
    logic [TW-1:0]    rd_b;

    always_comb begin
        quad = phase_in[PHASE_W-1 -: 2];
        idx  = phase_in[RES_W +: IDX_W];
        res  = phase_in[RES_W-1:0];
        mir  = IDX_W'(TBL_N - 1) - idx;
        rd_a = tbl[idx];
        rd_b = tbl[mir];
        seed_d.vld  = vld_in;
        seed_d.quad = quad;
        if (quad[0]) begin
            seed_d.x = $signed(XW'(rd_a));
            seed_d.y = $signed(XW'(rd_b));
        end else begin
            seed_d.x = $signed(XW'(rd_b));
            seed_d.y = $signed(XW'(rd_a));
        end
        seed_d.z = $signed((ZW'(res) - ZW'(HALF)) << ZGUARD);
    end

    always_ff @(posedge clk) begin
        seed_q <= seed_d;
        if (rst) seed_q.vld <= 1'b0;
    end

    assign vld_o  = seed_q.vld;
    assign quad_o = seed_q.quad;
    assign x_o    = seed_q.x;
    assign y_o    = seed_q.y;
    assign z_o    = seed_q.z;

    localparam logic signed [XW:0] AMPG_X = (XW+1)'(AMPG);

    // R2
    seed_on_circle_chk: assert property (@(posedge clk) disable iff (rst)
        seed_q.vld |-> (seed_q.x >= 0 && seed_q.y >= 0 &&
                        {seed_q.x[XW-1], seed_q.x} <= AMPG_X &&
                        {seed_q.y[XW-1], seed_q.y} <= AMPG_X &&
                        ({seed_q.x[XW-1], seed_q.x} + {seed_q.y[XW-1], seed_q.y}) >= AMPG_X));

endmodule

// File: rtl/sincos_rot_stage.sv
module sincos_rot_stage #(
    parameter int XW    = 21,
    parameter int ZW    = 16,
    parameter int SHIFT = 9,
    parameter int ANG   = 5215
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_in,
    input  logic [1:0]           quad_in,
    input  logic signed [XW-1:0] x_in,
    input  logic signed [XW-1:0] y_in,
    input  logic signed [ZW-1:0] z_in,
    output logic                 vld_o,
    output logic [1:0]           quad_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    localparam logic signed [ZW-1:0] ANG_Z = ZW'(ANG);
    localparam logic signed [ZW-1:0] LIM_Z = ZW'(2 * ANG);

    typedef struct packed {
        logic                 vld;
        logic [1:0]           quad;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
    } rot_t;

    rot_t rot_d, rot_q;
    logic                 z_pos;
    logic                 ccw;
    logic signed [XW-1:0] xs;
    logic signed [XW-1:0] ys;
    logic signed [ZW-1:0] zt;

    always_comb begin
        z_pos = (z_in > 0);
        // sectors with odd quadrant carry a swapped seed: turn the other way
        ccw   = z_pos ^ quad_in[0];
        xs    = x_in >>> SHIFT;
        ys    = y_in >>> SHIFT;
        rot_d.vld  = vld_in;
        rot_d.quad = quad_in;
        if (ccw) begin
            rot_d.x = x_in - ys;
            rot_d.y = y_in + xs;
        end else begin
            rot_d.x = x_in + ys;
            rot_d.y = y_in - xs;
        end
        zt      = z_pos ? (z_in - ANG_Z) : (z_in + ANG_Z);
        rot_d.z = zt <<< 1;
    end

    always_ff @(posedge clk) begin
        rot_q <= rot_d;
        if (rst) rot_q.vld <= 1'b0;
    end

    assign vld_o  = rot_q.vld;
    assign quad_o = rot_q.quad;
    assign x_o    = rot_q.x;
    assign y_o    = rot_q.y;
    assign z_o    = rot_q.z;

    // R2
    residual_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rot_q.vld |-> (rot_q.z <= LIM_Z && rot_q.z >= -LIM_Z));

endmodule

// File: rtl/sincos_fold.sv
module sincos_fold #(
    parameter int XW     = 21,
    parameter int OUT_W  = 16,
    parameter int XGUARD = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_in,
    input  logic [1:0]              quad_in,
    input  logic signed [XW-1:0]    x_in,
    input  logic signed [XW-1:0]    y_in,
    output logic                    vld_o,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o
);
    localparam int AMP = (1 << (OUT_W - 1)) - 1;
    localparam logic signed [XW-1:0] AMP_X = XW'(AMP);
    localparam logic signed [XW-1:0] RND_X = XW'(1 << (XGUARD - 1));

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
    } fold_t;

    function automatic logic signed [OUT_W-1:0] clip(input logic signed [XW-1:0] v);
        if (v < 0)          return '0;
        else if (v > AMP_X) return OUT_W'(AMP);
        else                return v[OUT_W-1:0];
    endfunction

    fold_t fold_d, fold_q;
    logic signed [XW-1:0]    xr;
    logic signed [XW-1:0]    yr;
    logic signed [OUT_W-1:0] xm;
    logic signed [OUT_W-1:0] ym;

    always_comb begin
        xr = (x_in + RND_X) >>> XGUARD;
        yr = (y_in + RND_X) >>> XGUARD;
        xm = clip(xr);
        ym = clip(yr);
        fold_d.vld = vld_in;
        fold_d.c   = (quad_in[1] ^ quad_in[0]) ? -xm : xm;
        fold_d.s   = quad_in[1] ? -ym : ym;
    end

    always_ff @(posedge clk) begin
        fold_q <= fold_d;
        if (rst) fold_q.vld <= 1'b0;
    end

    assign vld_o = fold_q.vld;
    assign sin_o = fold_q.s;
    assign cos_o = fold_q.c;

endmodule

// File: rtl/sincos_seeded.sv
module sincos_seeded #(
    parameter int PHASE_W = 16,
    parameter int IDX_W   = 9,
    parameter int OUT_W   = 16,
    parameter int STAGES  = 7,
    parameter int XGUARD  = 4,
    parameter int ZGUARD  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    phase_vld,
    input  logic [PHASE_W-1:0]      phase,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out
);
    localparam int RES_W = PHASE_W - 2 - IDX_W;
    localparam int XW    = OUT_W + XGUARD + 1;
    localparam int TW    = OUT_W - 1 + XGUARD;
    localparam int ZW    = RES_W + ZGUARD + 3;
    localparam int AMP   = (1 << (OUT_W - 1)) - 1;
    localparam int AMPG  = AMP << XGUARD;
    localparam int ANG   = sincos_seed_pkg::step_angle(RES_W, ZGUARD);

    logic                 st_vld  [STAGES+1];
    logic [1:0]           st_quad [STAGES+1];
    logic signed [XW-1:0] st_x    [STAGES+1];
    logic signed [XW-1:0] st_y    [STAGES+1];
    logic signed [ZW-1:0] st_z    [STAGES+1];

    sincos_seed_rom #(
        .PHASE_W(PHASE_W), .IDX_W(IDX_W), .XW(XW), .TW(TW), .ZW(ZW),
        .ZGUARD(ZGUARD), .STAGES(STAGES), .AMPG(AMPG)
    ) u_seed (
        .clk(clk), .rst(rst), .vld_in(phase_vld), .phase_in(phase),
        .vld_o(st_vld[0]), .quad_o(st_quad[0]),
        .x_o(st_x[0]), .y_o(st_y[0]), .z_o(st_z[0])
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_rot
        sincos_rot_stage #(
            .XW(XW), .ZW(ZW), .SHIFT(IDX_W + g), .ANG(ANG)
        ) u_rot (
            .clk(clk), .rst(rst),
            .vld_in(st_vld[g]), .quad_in(st_quad[g]),
            .x_in(st_x[g]), .y_in(st_y[g]), .z_in(st_z[g]),
            .vld_o(st_vld[g+1]), .quad_o(st_quad[g+1]),
            .x_o(st_x[g+1]), .y_o(st_y[g+1]), .z_o(st_z[g+1])
        );
    end

    sincos_fold #(
        .XW(XW), .OUT_W(OUT_W), .XGUARD(XGUARD)
    ) u_fold (
        .clk(clk), .rst(rst),
        .vld_in(st_vld[STAGES]), .quad_in(st_quad[STAGES]),
        .x_in(st_x[STAGES]), .y_in(st_y[STAGES]),
        .vld_o(out_vld), .sin_o(sin_out), .cos_o(cos_out)
    );

    // R4
    reset_flush_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_vld);

    // R7
    amp_limit_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (sin_out <= AMP && sin_out >= -AMP &&
                     cos_out <= AMP && cos_out >= -AMP));

endmodule

// File: tb/tb_sincos_seeded.sv
module tb_sincos_seeded;
    localparam int PW   = 16;
    localparam int OW   = 16;
    localparam int ST   = 7;
    localparam int LAT  = ST + 2;
    localparam int AMP  = 32767;
    localparam int TOL  = 3;
    localparam int QTR  = 1 << (PW - 2);
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst;
    logic pv;
    logic [PW-1:0] ph;
    logic ov;
    logic signed [OW-1:0] so;
    logic signed [OW-1:0] co;

    always #10 clk = ~clk;

    sincos_seeded #(.PHASE_W(PW), .IDX_W(9), .OUT_W(OW), .STAGES(ST)) dut (
        .clk(clk), .rst(rst), .phase_vld(pv), .phase(ph),
        .out_vld(ov), .sin_out(so), .cos_out(co)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_run = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    int q_ph[$];
    int q_cy[$];
    int ref_low = -1;
    int ref_s = 0;
    int ref_c = 0;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int p, input bit track);
        @(negedge clk);
        pv = v;
        ph = p[PW-1:0];
        if (v && track) begin
            q_ph.push_back(p);
            q_cy.push_back(cyc);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en && !rst && ov) begin
            if (q_ph.size() == 0) begin
                chk(1'b0, "R3", "result with no pending phase", 1, 0);
            end else begin
                int p, dc, s, c, es, ec, qd, low;
                real ang;
                p  = q_ph.pop_front();
                dc = q_cy.pop_front();
                s  = so;
                c  = co;
                chk(cyc == dc + LAT, "R3", "latency", cyc - dc, LAT);
                ang = TWO_PI * real'(p) / real'(1 << PW);
                es  = int'(real'(AMP) * $sin(ang));
                ec  = int'(real'(AMP) * $cos(ang));
                chk(iabs(s - es) <= TOL, "R2", $sformatf("sine (R1 map) phase %0d", p), s, es);
                chk(iabs(c - ec) <= TOL, "R2", $sformatf("cosine (R1 map) phase %0d", p), c, ec);
                chk(iabs(s) <= AMP && iabs(c) <= AMP, "R7", "magnitude", iabs(s) > iabs(c) ? s : c, AMP);
                qd  = p / QTR;
                low = p % QTR;
                chk(!(s < 0 && qd < 2), "R6", $sformatf("sine sign phase %0d", p), s, 0);
                chk(!(c < 0 && (qd == 0 || qd == 3)), "R6", $sformatf("cosine sign phase %0d", p), c, 0);
                if (qd == 0) begin
                    ref_low = low;
                    ref_s   = s;
                    ref_c   = c;
                end else if (low == ref_low) begin
                    int xs, xc;
                    case (qd)
                        1:       begin xc = -ref_s; xs =  ref_c; end
                        2:       begin xc = -ref_c; xs = -ref_s; end
                        default: begin xc =  ref_s; xs = -ref_c; end
                    endcase
                    chk(s == xs, "R5", $sformatf("sine symmetry phase %0d", p), s, xs);
                    chk(c == xc, "R5", $sformatf("cosine symmetry phase %0d", p), c, xc);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit bad;
        logic [15:0] lfsr;
        rst = 1'b1;
        pv  = 1'b0;
        ph  = '0;
        repeat (3) @(negedge clk);
        chk(ov == 1'b0, "R4", "valid during reset", int'(ov), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ov == 1'b0, "R4", "valid after release", int'(ov), 0);

        // R4: reset with phases in flight drops them
        drive(1'b1, 100, 1'b0);
        drive(1'b1, 200, 1'b0);
        drive(1'b1, 300, 1'b0);
        @(negedge clk);
        pv  = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < LAT + 4; i++) begin
            @(negedge clk);
            if (ov) bad = 1'b1;
        end
        chk(!bad, "R4", "in-flight phase survived reset", int'(bad), 0);

        mon_en = 1'b1;

        // full sweep, quarter-turn copies back to back (R1 R2 R3 R5 R6 R7)
        for (int b = 0; b < QTR; b++) begin
            for (int k = 0; k < 4; k++) begin
                drive(1'b1, b + k * QTR, 1'b1);
            end
        end
        drive(1'b0, 0, 1'b0);
        repeat (LAT + 2) @(negedge clk);
        chk(q_ph.size() == 0, "R3", "results missing after sweep", q_ph.size(), 0);

        // R3: irregular valid pattern with random phases
        lfsr = 16'hACE1;
        for (int i = 0; i < 800; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] ^ lfsr[5], int'(lfsr), 1'b1);
        end
        drive(1'b0, 0, 1'b0);
        repeat (LAT + 4) @(negedge clk);
        chk(q_ph.size() == 0, "R3", "results missing after gapped run", q_ph.size(), 0);
        chk(ov == 1'b0, "R3", "valid while idle", int'(ov), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule